// File: doc/BRIEF.md
# Overlapping Finite-Window Property Monitor

This block is a synthesizable run-time checker. It sits beside a design and watches four single-bit signals: a condition bit, a data bit, an enable bit and an acknowledge bit. It judges three fixed implication properties. Each property has an assumption part and a commitment part, both tied to a reference cycle t. A fresh attempt of every property starts on every clock cycle. Because a window is up to eight cycles long, many attempts are live at once, and their windows interleave.

The monitor keeps a short history of every watched signal, together with a validity trail that starts at reset release. From this history it decides the verdict of every live attempt. An attempt whose assumption turns out false is silently dropped. Each property drives a fail pulse, a pass pulse and a saturating failure counter. The host can read the counter at any time.

Cycle numbering: the inputs sampled at clock edge n are "cycle n". A verdict decided at cycle n shows on the pulse outputs during the clock period right after edge n. A failure counter changes at edge n+1.

Top module: `window_monitor`

## Requirements
- R1: Property A (assume condition=0 at t and data=1 at t+2): when enable is 0 at t+4, failA pulses for cycle t+4.
- R2: Property A, with the assumption held and enable=1 at t+4: at t+7, failA pulses if ack differs from data in that same cycle, and passA pulses otherwise.
- R3: Property B (assume condition=0 at t; for every cycle c from t+1 through t+4, enable at c must equal data at c-2): failB pulses at the first mismatching cycle, and never again for that attempt.
- R4: Property B: passB pulses at t+4 when no cycle of the window mismatched.
- R5: Property C (assume condition=0 at t; freeze data at t; data must equal the frozen value on some cycle from t+1 through t+4): passC pulses at the first matching cycle.
- R6: Property C: failC pulses at t+4 only if no cycle of the window matched.
- R7: An attempt whose condition bit is 1 at t, or whose property A data bit is 0 at t+2, produces no pulse at all.
- R8: rst is synchronous and active high. It clears all history. No attempt anchored before reset release is judged. A property B attempt is judged only if cycle t-1 also follows the release. All pulses stay 0 through reset and the cycle after it, and the counters read 0.
- R9: Each failure counter is CNT_W bits wide (default 16). It rises by one at the edge after each cycle in which its fail pulse is high. It stops at its all-ones value.
- R10: The six pulses of a property set are ORed across all overlapping attempts. Pulses for cycle n appear right after edge n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| watchCond | input | 1 | Condition bit used by all assumptions |
| watchData | input | 1 | Data bit: referenced, looked back on, frozen |
| watchEnable | input | 1 | Enable bit checked by commitments |
| watchAck | input | 1 | Acknowledge bit compared at t+7 |
| failA | output | 1 | Property A violation pulse |
| passA | output | 1 | Property A success pulse |
| failB | output | 1 | Property B violation pulse |
| passB | output | 1 | Property B success pulse |
| failC | output | 1 | Property C violation pulse |
| passC | output | 1 | Property C success pulse |
| countA | output | CNT_W | Saturating failure count of property A |
| countB | output | CNT_W | Saturating failure count of property B |
| countC | output | CNT_W | Saturating failure count of property C |

## Verification
The hardest case is a cycle where several attempts of one property are live and disagree. In one cycle, one attempt may fail on its first mismatch while an older attempt of the same property was already counted and must stay quiet. In the same cycle, a younger attempt may still be pending. The stimulus gets there with long stretches where enable copies the data bit from two cycles back and the condition bit is mostly low. Rare flips then land inside many open windows at once. Random traffic and a reset in the middle of activity cover the start-of-history cases. A long, steady violating pattern drives a counter into saturation.

// File: rtl/wmon_pkg.sv
package wmon_pkg;
  // one sampled cycle of the watched signals
  typedef struct packed {
    logic cond;
    logic data;
    logic enable;
    logic ack;
  } sample_t;

  // verdict strobes handed from the judge to the history/counter datapath
  typedef struct packed {
    logic failA;
    logic passA;
    logic failB;
    logic passB;
    logic failC;
    logic passC;
  } verdict_t;

  localparam int NUM_PROPS = 3;
  // property A time offsets relative to the anchor
  localparam int A_DATA_OFS = 2;
  localparam int A_EN_OFS   = 4;
  localparam int A_END_OFS  = 7;
  // window length of properties B and C, and look-back distance of B
  localparam int WIN        = 4;
  localparam int B_LOOKBACK = 2;
  // history needed to reach the oldest referenced cycle
  localparam int MIN_DEPTH  = A_END_OFS + 1;
endpackage

// File: rtl/wmon_history.sv
module wmon_history
  import wmon_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  sample_t           sIn,
  input  verdict_t          strobe,
  output sample_t           hist [DEPTH],
  output logic [DEPTH-1:0]  vld,
  output logic [CNT_W-1:0]  failCnt [NUM_PROPS]
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_PROPS-1:0] failVec;
  assign failVec = {strobe.failC, strobe.failB, strobe.failA};

  // shift registers: index 0 holds the most recently sampled cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
    end else begin
      vld <= {vld[DEPTH-2:0], 1'b1};
      hist[0] <= sIn;
      for (int i = 1; i < DEPTH; i++) hist[i] <= hist[i-1];
    end
  end

  // one saturating failure counter per property
  for (genvar p = 0; p < NUM_PROPS; p++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst) failCnt[p] <= '0;
      else if (failVec[p] && failCnt[p] != CNT_MAX) failCnt[p] <= failCnt[p] + 1'b1;
    end
  end
endmodule

// File: rtl/wmon_judge.sv
module wmon_judge
  import wmon_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  sample_t          hist [DEPTH],
  input  logic [DEPTH-1:0] vld,
  output verdict_t         strobe
);
  // lookback mismatch of property B at each recent cycle
  logic [WIN-1:0] bMiss;
  logic           aHeld;
  logic           cleanB, noMatchC;

  always_comb begin
    for (int k = 0; k < WIN; k++)
      bMiss[k] = hist[k].enable != hist[k+B_LOOKBACK].data;
  end

  // property A: assumption plus the t+4 commitment held, judged at t+7
  assign aHeld = vld[A_END_OFS] && !hist[A_END_OFS].cond
              && hist[A_END_OFS-A_DATA_OFS].data
              && hist[A_END_OFS-A_EN_OFS].enable;

  always_comb begin
    strobe = '0;
    // property A
    strobe.failA = (vld[A_EN_OFS] && !hist[A_EN_OFS].cond
                    && hist[A_EN_OFS-A_DATA_OFS].data && !hist[0].enable)
                || (aHeld && (hist[0].ack != hist[0].data));
    strobe.passA = aHeld && (hist[0].ack == hist[0].data);

    // properties B and C: attempt anchored j cycles ago
    for (int j = 1; j <= WIN; j++) begin
      cleanB   = 1'b1;
      noMatchC = 1'b1;
      for (int k = 1; k < WIN; k++) begin
        if (k < j) begin
          cleanB   = cleanB && !bMiss[k];
          noMatchC = noMatchC && (hist[k].data != hist[j].data);
        end
      end
      if (vld[j+1] && !hist[j].cond && bMiss[0] && cleanB)
        strobe.failB = 1'b1;
      if (vld[j] && !hist[j].cond && noMatchC && (hist[0].data == hist[j].data))
        strobe.passC = 1'b1;
    end

    // window-closing verdicts for the attempt anchored WIN cycles ago
    strobe.passB = vld[WIN+1] && !hist[WIN].cond && (bMiss == '0);
    noMatchC = 1'b1;
    for (int k = 0; k < WIN; k++)
      noMatchC = noMatchC && (hist[k].data != hist[WIN].data);
    strobe.failC = vld[WIN] && !hist[WIN].cond && noMatchC;
  end
endmodule

// File: rtl/window_monitor.sv
module window_monitor
  import wmon_pkg::*;
#(
  parameter int DEPTH = MIN_DEPTH,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             watchCond,
  input  logic             watchData,
  input  logic             watchEnable,
  input  logic             watchAck,
  output logic             failA,
  output logic             passA,
  output logic             failB,
  output logic             passB,
  output logic             failC,
  output logic             passC,
  output logic [CNT_W-1:0] countA,
  output logic [CNT_W-1:0] countB,
  output logic [CNT_W-1:0] countC
);
  sample_t          sIn;
  sample_t          hist [DEPTH];
  logic [DEPTH-1:0] vld;
  verdict_t         strobe;
  logic [CNT_W-1:0] failCnt [NUM_PROPS];

  assign sIn = '{cond: watchCond, data: watchData, enable: watchEnable, ack: watchAck};

  wmon_history #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_hist (
    .clk(clk), .rst(rst), .sIn(sIn), .strobe(strobe),
    .hist(hist), .vld(vld), .failCnt(failCnt)
  );

  wmon_judge #(.DEPTH(DEPTH)) u_judge (
    .hist(hist), .vld(vld), .strobe(strobe)
  );

  assign failA  = strobe.failA;
  assign passA  = strobe.passA;
  assign failB  = strobe.failB;
  assign passB  = strobe.passB;
  assign failC  = strobe.failC;
  assign passC  = strobe.passC;
  assign countA = failCnt[0];
  assign countB = failCnt[1];
  assign countC = failCnt[2];
endmodule

// File: rtl/wmon_checker.sv
module wmon_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             watchData,
  input logic             watchEnable,
  input logic             watchAck,
  input logic             failA,
  input logic             passA,
  input logic             failB,
  input logic             passB,
  input logic             failC,
  input logic             passC,
  input logic [CNT_W-1:0] countA
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  // R2
  pass_a_ack_match_chk: assert property (@(posedge clk) disable iff (rst)
    passA |-> ($past(watchAck) == $past(watchData)));

  // R3
  fail_b_mismatch_chk: assert property (@(posedge clk) disable iff (rst)
    failB |-> ($past(watchEnable) != $past(watchData, 3)));

  // R4
  pass_b_match_chk: assert property (@(posedge clk) disable iff (rst)
    passB |-> ($past(watchEnable) == $past(watchData, 3)));

  // R6
  fail_c_steady_chk: assert property (@(posedge clk) disable iff (rst)
    failC |-> ($past(watchData) == $past(watchData, 2)));

  // R8
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !(failA || passA || failB || passB || failC || passC) && countA == '0);

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (failA && countA != CMAX) |=> countA == $past(countA) + 1'b1);

  // R9
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !failA |=> $stable(countA));

  // R9
  count_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    countA == CMAX |=> countA == CMAX);
endmodule

bind window_monitor wmon_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .watchData(watchData), .watchEnable(watchEnable),
  .watchAck(watchAck), .failA(failA), .passA(passA), .failB(failB),
  .passB(passB), .failC(failC), .passC(passC), .countA(countA)
);

// File: tb/sim_window_monitor.sv
`timescale 1ns/1ps
module sim_window_monitor;
  localparam int CNT_W = 16;
  localparam int MAXC  = 80000;
  localparam int LIMIT = 150000;
  localparam logic [CNT_W-1:0] CMAX = '1;

  typedef struct {
    logic [5:0]       pulses;   // {failA,passA,failB,passB,failC,passC}
    logic [CNT_W-1:0] cnt [3];
    bit               inRst;
  } item_t;

  logic clk = 1'b0;
  logic rst, wc, wd, we, wa;
  logic fA, pA, fB, pB, fC, pC;
  logic [CNT_W-1:0] cA, cB, cC;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit sx [MAXC];
  bit sy [MAXC];
  bit se [MAXC];
  bit sa [MAXC];
  int cyc  = 0;
  int base = 0;
  logic [5:0]       prevExp = '0;
  logic [CNT_W-1:0] expCnt [3] = '{default: '0};
  item_t sbq [$];

  always #2 clk = ~clk;

  window_monitor #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .watchCond(wc), .watchData(wd), .watchEnable(we),
    .watchAck(wa), .failA(fA), .passA(pA), .failB(fB), .passB(pB),
    .failC(fC), .passC(pC), .countA(cA), .countB(cB), .countC(cC)
  );

  // reference: judge every live attempt on its own
  function automatic logic [5:0] expect_at(int n);
    logic ffA, ppA, ffB, ppB, ffC, ppC;
    int t, first, hit;
    ffA = 0; ppA = 0; ffB = 0; ppB = 0; ffC = 0; ppC = 0;
    t = n - 4;
    if (t >= base && !sx[t] && sy[t+2] && !se[n]) ffA = 1;
    t = n - 7;
    if (t >= base && !sx[t] && sy[t+2] && se[t+4]) begin
      if (sa[n] != sy[n]) ffA = 1; else ppA = 1;
    end
    for (int j = 1; j <= 4; j++) begin
      t = n - j;
      if (t - 1 >= base && !sx[t]) begin
        first = 0;
        for (int k = 1; k <= j; k++)
          if (first == 0 && se[t+k] != sy[t+k-2]) first = k;
        if (first == j) ffB = 1;
        if (j == 4 && first == 0) ppB = 1;
      end
      if (t >= base && !sx[t]) begin
        hit = 0;
        for (int k = 1; k <= j; k++)
          if (hit == 0 && sy[t+k] == sy[t]) hit = k;
        if (hit == j) ppC = 1;
        if (j == 4 && hit == 0) ffC = 1;
      end
    end
    return {ffA, ppA, ffB, ppB, ffC, ppC};
  endfunction

  // driver: apply one cycle, push the expected outcome for that edge
  task automatic step(bit r, bit x, bit y, bit e, bit a);
    item_t it;
    rst = r; wc = x; wd = y; we = e; wa = a;
    sx[cyc] = x; sy[cyc] = y; se[cyc] = e; sa[cyc] = a;
    for (int p = 0; p < 3; p++) begin
      if (r) expCnt[p] = '0;
      else if (prevExp[5 - 2*p] && expCnt[p] != CMAX) expCnt[p] = expCnt[p] + 1'b1;
    end
    if (r) begin
      base = cyc + 1;
      it.pulses = '0;
    end else begin
      it.pulses = expect_at(cyc);
    end
    prevExp = it.pulses;
    it.cnt = expCnt;
    it.inRst = r;
    sbq.push_back(it);
    cyc++;
    @(negedge clk);
  endtask

  function automatic void cmp(bit cond, string tag, int act, int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle index", tag, act, exp);
    end
  endfunction

  // monitor: pop and compare shortly after each edge
  always @(posedge clk) begin
    #1;
    if (sbq.size() > 0) begin
      item_t it;
      logic [5:0] act;
      it = sbq.pop_front();
      act = {fA, pA, fB, pB, fC, pC};
      if (it.inRst) begin
        cmp(act == 6'b0, "R8 pulses during reset", act, 0);
      end else begin
        cmp(act[5] == it.pulses[5], "R1 R2 R7 R10 failA", act[5], it.pulses[5]);
        cmp(act[4] == it.pulses[4], "R2 R7 passA", act[4], it.pulses[4]);
        cmp(act[3] == it.pulses[3], "R3 R8 failB", act[3], it.pulses[3]);
        cmp(act[2] == it.pulses[2], "R4 R8 passB", act[2], it.pulses[2]);
        cmp(act[1] == it.pulses[1], "R6 failC", act[1], it.pulses[1]);
        cmp(act[0] == it.pulses[0], "R5 passC", act[0], it.pulses[0]);
      end
      cmp(cA == it.cnt[0], "R9 countA", cA, it.cnt[0]);
      cmp(cB == it.cnt[1], "R9 countB", cB, it.cnt[1]);
      cmp(cC == it.cnt[2], "R9 countC", cC, it.cnt[2]);
    end
  end

  initial begin
    bit x, y;
    void'($urandom(7));
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0);
    // random traffic, condition low half the time
    for (int i = 0; i < 500; i++)
      step(0, $urandom_range(1), $urandom_range(1), $urandom_range(1), $urandom_range(1));
    // enable tracks data two cycles back, rare flips: many overlapping B windows
    for (int i = 0; i < 600; i++) begin
      y = $urandom_range(1);
      x = ($urandom_range(7) == 0);
      step(0, x, y, sy[cyc-2] ^ ($urandom_range(15) == 0), ($urandom_range(3) != 0) ? y : ~y);
    end
    // steady data with rare toggles: property C windows with late or no match
    for (int i = 0; i < 400; i++) begin
      y = ($urandom_range(5) == 0) ? ~sy[cyc-1] : sy[cyc-1];
      step(0, $urandom_range(3) == 0, y, $urandom_range(1), $urandom_range(1));
    end
    // reset in the middle of live attempts (R8)
    step(1, 0, 1, 1, 1);
    step(1, 0, 0, 0, 0);
    for (int i = 0; i < 300; i++)
      step(0, $urandom_range(1), $urandom_range(1), $urandom_range(1), $urandom_range(1));
    // constant violation of A on every cycle: counter saturation (R9)
    for (int i = 0; i < 66000; i++) step(0, 0, 1, 0, 0);
    for (int i = 0; i < 50; i++)
      step(0, $urandom_range(1), $urandom_range(1), $urandom_range(1), $urandom_range(1));
    step(1, 0, 0, 0, 0);
    for (int i = 0; i < 20; i++) step(0, 0, 1, 0, 1);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4 * LIMIT);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired, actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule